// File: doc/BRIEF.md
# Dual-Region CRC-8 Configuration Checker

This block checks an 11-byte configuration image after it has been loaded into a register array. The image holds two protected regions, each followed by its own checksum byte. The general settings sit in bytes 0 to 3, with their checksum in byte 4. The counter preload value sits in bytes 5 to 9, with its checksum in byte 10.

A one-cycle start pulse takes a snapshot of the image. The block then runs one CRC-8 engine over the nine data bytes, one bit per clock, most significant bit first. The engine is cleared to zero before each region. At the end of each region, the computed value is compared with the stored checksum byte.

When the run ends, the block raises `done` and presents the result in four ways:
- a mismatch flag for the general region;
- a mismatch flag for the preload region;
- an active-low error pin that combines both flags;
- an active-high error bit, meant to be appended to a serial position frame.

The image is a parallel input and start/done is a plain control handshake. No streaming interface is involved, so no back-pressure rules apply.

Top module: `cfg_crc_checker`

## Requirements
- R1: Each CRC step takes one data bit. It shifts the 8-bit register left by one. When the register's top bit differed from the data bit before the shift, it also XORs the result with 0x2F (x^8+x^5+x^3+x^2+x+1). Bits are fed most significant bit first within each byte, and bytes are fed in ascending index order.
- R2: The CRC register starts from zero for each region, so the preload-region result does not depend on the general-region bytes.
- R3: `mism_gen` is 1 exactly when the CRC over bytes 0..3 differs from byte 4. Byte k of `image` is `image[8k+7:8k]`.
- R4: `mism_preload` is 1 exactly when the CRC over bytes 5..9 differs from byte 10.
- R5: `frame_err_bit` equals `done & (mism_gen | mism_preload)`, and `crc_err_n` is its inverse. While `done` is 0, `crc_err_n` is 1.
- R6: `done` rises 72 clock edges after the edge that samples `start` high while the block is idle. `busy` is 1 throughout the run, and `busy` and `done` are never both 1.
- R7: A `start` pulse while `busy` is 1 is ignored and does not change when `done` rises.
- R8: The image is captured on the accepted start edge. Changes to `image` during a run do not affect the result.
- R9: While `done` is 1 and no new start arrives, `done` and both mismatch flags hold. A start while done begins a new run: one edge later `done` is 0 and `busy` is 1.
- R10: After reset, `busy`, `done`, `frame_err_bit` and both mismatch flags are 0, and `crc_err_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse; accepted only while idle |
| image | input | 88 | Configuration image; byte k at bits 8k+7..8k |
| busy | output | 1 | Check in progress |
| done | output | 1 | Result valid, held until next start |
| crc_err_n | output | 1 | Active-low combined checksum error |
| frame_err_bit | output | 1 | Active-high error bit for the readout frame |
| mism_gen | output | 1 | General region checksum mismatch |
| mism_preload | output | 1 | Preload region checksum mismatch |

## Verification
A corrupted CRC register or a wrong bit selection stays hidden while the run is in progress. It appears only when `done` rises, 72 cycles after start, as a wrong mismatch flag for the region concerned. A step counter that skips or stalls shows up directly as a `done` latency other than 72 cycles. A region seed that is not cleared shows up as a false preload mismatch on images whose checksums are both valid. Random images, some with one byte corrupted, are therefore compared against a bitwise model, and every run also checks latency and the hold behaviour after `done`.

// File: rtl/cfgcrc_pkg.sv
package cfgcrc_pkg;
  localparam int BYTE_W = 8;
  localparam int BSEL_W = 3;
  typedef logic [BYTE_W-1:0] byte_t;

  // One bitwise CRC step, data fed MSB first
  function automatic byte_t crc_bit_step(byte_t crc, logic din, byte_t poly);
    byte_t sh;
    sh = {crc[BYTE_W-2:0], 1'b0};
    return (crc[BYTE_W-1] != din) ? (sh ^ poly) : sh;
  endfunction
endpackage

// File: rtl/cfgcrc_seq.sv
module cfgcrc_seq #(
  parameter int NUM_BYTES = 11,
  parameter int A_FIRST   = 0,
  parameter int A_LEN     = 4,
  parameter int B_FIRST   = 5,
  parameter int B_LEN     = 5,
  localparam int IDX_W    = $clog2(NUM_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy,
  output logic             launch,
  output logic [IDX_W-1:0] byte_idx,
  output logic [2:0]       bit_sel,
  output logic             end_a,
  output logic             end_b
);
  localparam int A_BITS = A_LEN * 8;
  localparam int TOTAL  = (A_LEN + B_LEN) * 8;
  localparam int CNT_W  = $clog2(TOTAL);
  localparam logic [CNT_W-1:0] LAST_A = CNT_W'(A_BITS - 1);
  localparam logic [CNT_W-1:0] LAST   = CNT_W'(TOTAL - 1);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] rel;
  logic [IDX_W-1:0] base;

  assign launch = start && !busy;
  assign end_a  = busy && (cnt == LAST_A);
  assign end_b  = busy && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (launch) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == LAST) busy <= 1'b0;
      else             cnt  <= cnt + 1'b1;
    end
  end

  always_comb begin
    if (cnt < CNT_W'(A_BITS)) begin
      rel  = cnt;
      base = IDX_W'(A_FIRST);
    end else begin
      rel  = cnt - CNT_W'(A_BITS);
      base = IDX_W'(B_FIRST);
    end
    byte_idx = base + IDX_W'(rel >> 3);
    bit_sel  = 3'd7 - rel[2:0];
  end

  // R6: a run advances by exactly one step per clock
  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && (cnt != LAST) |=> busy && (cnt == $past(cnt) + 1'b1));

  // R7: a start during a run does not rewind the step counter
  p_restart_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && (cnt != LAST) |=> cnt != '0);
endmodule

// File: rtl/cfgcrc_engine.sv
module cfgcrc_engine
  import cfgcrc_pkg::*;
#(
  parameter byte_t POLY = 8'h2F
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  launch,
  input  logic  step_en,
  input  logic  din,
  input  logic  seg_end,
  output byte_t crc_next
);
  byte_t crc_q;

  assign crc_next = crc_bit_step(crc_q, din, POLY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       crc_q <= '0;
    else if (launch)  crc_q <= '0;
    else if (step_en) crc_q <= seg_end ? byte_t'(0) : crc_next;
  end

  // R2: each region starts from a zero register
  p_seed_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && seg_end |=> crc_q == '0);
endmodule

// File: rtl/cfg_crc_checker.sv
module cfg_crc_checker
  import cfgcrc_pkg::*;
#(
  parameter int    NUM_BYTES = 11,
  parameter int    A_FIRST   = 0,
  parameter int    A_LEN     = 4,
  parameter int    B_FIRST   = 5,
  parameter int    B_LEN     = 5,
  parameter byte_t POLY      = 8'h2F,
  localparam int   IMG_W     = NUM_BYTES * BYTE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IMG_W-1:0] image,
  output logic             busy,
  output logic             done,
  output logic             crc_err_n,
  output logic             frame_err_bit,
  output logic             mism_gen,
  output logic             mism_preload
);
  localparam int IDX_W = $clog2(NUM_BYTES);

  logic [IMG_W-1:0] snap;
  logic             launch, end_a, end_b;
  logic [IDX_W-1:0] byte_idx;
  logic [2:0]       bit_sel;
  logic [IDX_W+2:0] bpos;
  logic             din;
  byte_t            crc_next;
  logic [1:0]       mism;

  cfgcrc_seq #(
    .NUM_BYTES(NUM_BYTES), .A_FIRST(A_FIRST), .A_LEN(A_LEN),
    .B_FIRST(B_FIRST), .B_LEN(B_LEN)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .launch(launch),
    .byte_idx(byte_idx), .bit_sel(bit_sel), .end_a(end_a), .end_b(end_b)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      snap <= '0;
    else if (launch) snap <= image;
  end

  assign bpos = {byte_idx, bit_sel};
  assign din  = snap[bpos];

  cfgcrc_engine #(.POLY(POLY)) u_engine (
    .clk(clk), .rst_n(rst_n), .launch(launch), .step_en(busy),
    .din(din), .seg_end(end_a), .crc_next(crc_next)
  );

  for (genvar r = 0; r < 2; r++) begin : g_region
    localparam int CHK = (r == 0) ? (A_FIRST + A_LEN) : (B_FIRST + B_LEN);
    logic hit;
    assign hit = (r == 0) ? end_a : end_b;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mism[r] <= 1'b0;
      else if (launch) mism[r] <= 1'b0;
      else if (hit)    mism[r] <= (crc_next != snap[CHK*BYTE_W +: BYTE_W]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      done <= 1'b0;
    else if (launch) done <= 1'b0;
    else if (end_b)  done <= 1'b1;
  end

  assign mism_gen      = mism[0];
  assign mism_preload  = mism[1];
  assign frame_err_bit = done && (mism[0] || mism[1]);
  assign crc_err_n     = !frame_err_bit;

  // R5: no error indication before a result exists
  p_err_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> crc_err_n && !frame_err_bit);

  // R6: busy and done never overlap
  p_busy_done_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R9: results hold while done and no new start
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(mism));

  // R9: a start while done clears done on the next edge
  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done && start |=> !done && busy);
endmodule

// File: tb/cfg_crc_checker_bench.sv
module cfg_crc_checker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [87:0] image = '0;
  logic busy, done, crc_err_n, frame_err_bit, mism_gen, mism_preload;
  int n_chk = 0;
  int n_bad = 0;

  always #5ns clk = ~clk;

  cfg_crc_checker u_cfg_crc_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .image(image), .busy(busy),
    .done(done), .crc_err_n(crc_err_n), .frame_err_bit(frame_err_bit),
    .mism_gen(mism_gen), .mism_preload(mism_preload)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] crc_model(logic [87:0] img, int first, int len);
    logic [7:0] c = 8'h00;
    for (int b = first; b < first + len; b++)
      for (int i = 7; i >= 0; i--) begin
        logic d = img[8*b + i];
        logic top = c[7];
        c = {c[6:0], 1'b0};
        if (top != d) c = c ^ 8'h2F;
      end
    return c;
  endfunction

  function automatic logic [87:0] make_valid(logic [87:0] img);
    logic [87:0] o = img;
    o[4*8 +: 8]  = crc_model(o, 0, 4);
    o[10*8 +: 8] = crc_model(o, 5, 5);
    return o;
  endfunction

  task automatic run_check(input logic [87:0] img, input bit poke_start,
                           input bit poke_img, input string tag);
    bit ea, eb;
    int cnt;
    logic ha, hb;
    ea = crc_model(img, 0, 4) != img[4*8 +: 8];
    eb = crc_model(img, 5, 5) != img[10*8 +: 8];
    image = img;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk({"R6 busy after start ", tag}, busy, 1);
    chk({"R9 done cleared ", tag}, done, 0);
    cnt = 0;
    while (cnt < 300) begin
      @(negedge clk);
      cnt++;
      start = 1'b0;
      if (poke_start && cnt == 20) start = 1'b1;
      if (poke_img && cnt == 30) image = ~img;
      if (done) break;
    end
    start = 1'b0;
    chk({"R6 R7 latency ", tag}, cnt, 72);
    chk({"R1 R3 gen mismatch ", tag}, mism_gen, ea);
    chk({"R1 R4 preload mismatch ", tag}, mism_preload, eb);
    chk({"R5 err_n ", tag}, crc_err_n, !(ea || eb));
    chk({"R5 frame bit ", tag}, frame_err_bit, ea || eb);
    ha = mism_gen; hb = mism_preload;
    image = ~img;
    repeat (3) @(negedge clk);
    chk({"R9 done held ", tag}, done, 1);
    chk({"R9 flags held ", tag}, {mism_gen, mism_preload}, {ha, hb});
  endtask

  initial begin
    #2_000_000ns;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [87:0] img;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 busy", busy, 0);
    chk("R10 done", done, 0);
    chk("R10 err_n", crc_err_n, 1);
    chk("R10 frame bit", frame_err_bit, 0);
    chk("R10 flags", {mism_gen, mism_preload}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: hand-computed value, bytes 00 00 00 01 give 0x2F
    img = '0; img[3*8 +: 8] = 8'h01; img[4*8 +: 8] = 8'h2F;
    run_check(img, 0, 0, "hand_ok");
    chk("R1 hand value accepted", mism_gen, 0);
    img[4*8 +: 8] = 8'h2E;
    run_check(img, 0, 0, "hand_bad");
    chk("R1 hand value rejected", mism_gen, 1);

    // all-zero image is valid
    run_check('0, 0, 0, "zeros");
    // all-ones data with zero checksums
    img = {88{1'b1}}; img[4*8 +: 8] = 8'h00; img[10*8 +: 8] = 8'h00;
    run_check(img, 0, 0, "ones");

    // R2: preload region checked from zero seed regardless of general bytes
    img = make_valid({$urandom(), $urandom(), $urandom()});
    img[0 +: 32] = 32'hA5C3_0F81;
    img[4*8 +: 8] = ~crc_model(img, 0, 4);
    run_check(img, 0, 0, "seed");
    chk("R2 preload valid with bad general", mism_preload, 0);

    // R7: start during a run ignored
    run_check(make_valid({$urandom(), $urandom(), $urandom()}), 1, 0, "R7_poke");
    // R8: image change during run ignored
    img = make_valid({$urandom(), $urandom(), $urandom()});
    img[7*8 +: 8] ^= 8'h10;
    run_check(img, 0, 1, "R8_change");

    // random images, some with one corrupted byte
    for (int k = 0; k < 40; k++) begin
      img = make_valid({$urandom(), $urandom(), $urandom()});
      if ($urandom_range(0, 3) != 0) begin
        int b = $urandom_range(0, 10);
        logic [7:0] m = 8'($urandom_range(1, 255));
        img[b*8 +: 8] ^= m;
      end
      run_check(img, k % 7 == 3, k % 5 == 2, "random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule